// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

The scheduler sits between a transmit frame queue and four transmit mailboxes of a CAN controller. It accepts one frame at a time over a valid/ready handshake and writes it into a mailbox. Each new frame gets a hardware priority no better than the frames before it, so the controller's own arbitration (best priority first, lowest mailbox number on a tie) sends frames in the order they were submitted. A six-bit position counter selects both the mailbox, through its two low bits, and the priority, through its four high bits. When this counter wraps, intake stops until every frame in flight has finished, because priority 0 would otherwise overtake older frames still waiting at priority 15.

Completion status comes back as per-mailbox ready, done and abort flags. A retire pointer follows the submit counter. It frees the oldest outstanding mailbox only once that mailbox reports an event, and it reports a transmit echo only for frames that really went out. Echoes therefore leave in submission order, whatever order the mailboxes finish in.

Top module: `can_tx_mbox_sched`

## Requirements
- R1: Counting accepted frames from reset as k = 0, 1, 2, ..., frame k is loaded into mailbox 12 + (k mod 4) with priority (k div 4) mod 16, where priority 0 is the most urgent.
- R2: A load drives `ld_valid_o` for six consecutive cycles with `ld_op_o` = 1 (disable, word 0), 2 (identifier: extended gives id in bits 28:0 with bit 29 set; standard gives id[10:0] in bits 28:18), 3 (enable: value 3 in bits 26:24, priority in bits 19:16), 4 (data bits 31:0), 5 (data bits 63:32), 6 (start: bit 23 set, remote flag in bit 20, length in bits 19:16). Mailbox and priority stay constant throughout.
- R3: `frm_ready_o` is high exactly when no load is running, no wrap hold is active and the mailbox selected by the counter reports ready. A frame is accepted when valid and ready are both high.
- R4: When a frame is offered while no load runs and no hold is active, but the selected mailbox is not ready, `frm_busy_o` is high in that cycle and the frame is not accepted.
- R5: After the start step of the load that completes position 63 (mailbox 15, priority 15), intake holds and `frm_ready_o` stays low. The hold ends once every outstanding frame has retired, and intake then resumes at mailbox 12 with priority 0.
- R6: At most one frame retires per cycle. It is always the oldest outstanding frame whose start step has been issued, and only when that frame's mailbox shows done. While it retires, `irq_dis_o` has exactly that mailbox's bit (bit = mailbox - 12) set; otherwise it is zero.
- R7: A retiring frame produces `echo_valid_o` with `echo_slot_o` = mailbox - 12 only if its mailbox shows ready and abort is clear. An aborted frame retires without an echo.
- R8: After reset nothing is outstanding. Nothing is loaded or retired, and with all mailboxes ready, intake is open.
- R9: `q_stop_o` is high whenever the wrap hold is active or the selected mailbox is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid_i | input | 1 | Frame offered |
| frm_ready_o | output | 1 | Frame can be accepted |
| frm_busy_o | output | 1 | Offer refused, selected mailbox busy |
| frm_id_i | input | 29 | Frame identifier |
| frm_ext_i | input | 1 | Extended identifier |
| frm_rtr_i | input | 1 | Remote request |
| frm_dlc_i | input | 4 | Data length code |
| frm_data_i | input | 64 | Payload |
| mb_rdy_i | input | 4 | Mailbox ready, per transmit mailbox |
| mb_done_i | input | 4 | Mailbox event pending |
| mb_abort_i | input | 4 | Mailbox transfer aborted |
| ld_valid_o | output | 1 | Load step valid |
| ld_op_o | output | 3 | Load step code |
| ld_mb_o | output | 4 | Absolute mailbox number |
| ld_prio_o | output | 4 | Priority of the load |
| ld_word_o | output | 32 | Value written by the step |
| q_stop_o | output | 1 | Queue must stop |
| echo_valid_o | output | 1 | Frame confirmed as sent |
| echo_slot_o | output | 2 | Echo slot (mailbox - 12) |
| irq_dis_o | output | 4 | Interrupt disable for the retired mailbox |

## Verification
The start step of a new load and the retirement of an older frame can fall in the same cycle. At that moment the submit and retire counters both move, and the hold flag can be set or released. The bench provokes this by completing the previous mailbox a varying number of cycles into each load during a long run up to the counter wrap. A behavioural model that counts frames with plain integers predicts every output in every cycle, so any disagreement on ready, hold or echo in those shared cycles is reported.

// File: rtl/can_tx_mbox_sched.sv
module can_tx_mbox_sched #(
  parameter int IDX_W   = 2,
  parameter int PRIO_W  = 4,
  parameter int MB_BASE = 12,
  parameter int MBN_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frm_valid_i,
  output logic                     frm_ready_o,
  output logic                     frm_busy_o,
  input  logic [28:0]              frm_id_i,
  input  logic                     frm_ext_i,
  input  logic                     frm_rtr_i,
  input  logic [3:0]               frm_dlc_i,
  input  logic [63:0]              frm_data_i,
  input  logic [(1<<IDX_W)-1:0]    mb_rdy_i,
  input  logic [(1<<IDX_W)-1:0]    mb_done_i,
  input  logic [(1<<IDX_W)-1:0]    mb_abort_i,
  output logic                     ld_valid_o,
  output logic [2:0]               ld_op_o,
  output logic [MBN_W-1:0]         ld_mb_o,
  output logic [PRIO_W-1:0]        ld_prio_o,
  output logic [31:0]              ld_word_o,
  output logic                     q_stop_o,
  output logic                     echo_valid_o,
  output logic [IDX_W-1:0]         echo_slot_o,
  output logic [(1<<IDX_W)-1:0]    irq_dis_o
);
  localparam int NMB   = 1 << IDX_W;
  localparam int CNT_W = IDX_W + PRIO_W;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_DIS = 3'd1, OP_ID = 3'd2,
                         OP_EN = 3'd3, OP_DLO = 3'd4, OP_DHI = 3'd5, OP_GO = 3'd6;
  localparam logic [MBN_W-1:0] LAST_MB = MBN_W'(MB_BASE + NMB - 1);

  logic [CNT_W:0]      nxt_q, echo_q;
  logic [2:0]          st_q;
  logic                hold_q;
  logic [IDX_W-1:0]    l_idx_q;
  logic [PRIO_W-1:0]   l_prio_q;
  logic [28:0]         l_id_q;
  logic                l_ext_q, l_rtr_q;
  logic [3:0]          l_dlc_q;
  logic [63:0]         l_data_q;

  wire [IDX_W-1:0] sel    = nxt_q[IDX_W-1:0];
  wire             idle   = (st_q == OP_IDLE);
  wire [CNT_W:0]   outst  = nxt_q - echo_q;
  wire [IDX_W-1:0] eslot  = echo_q[IDX_W-1:0];
  wire             retire = (outst != '0) && mb_done_i[eslot];
  wire             go     = (st_q == OP_GO);
  wire             wrap   = &nxt_q[CNT_W-1:0];
  wire             accept = frm_valid_i && frm_ready_o;

  assign frm_ready_o  = idle && !hold_q && mb_rdy_i[sel];
  assign frm_busy_o   = frm_valid_i && idle && !hold_q && !mb_rdy_i[sel];
  assign q_stop_o     = hold_q || !mb_rdy_i[sel];
  assign ld_valid_o   = !idle;
  assign ld_op_o      = st_q;
  assign ld_mb_o      = MBN_W'(MB_BASE) + MBN_W'(l_idx_q);
  assign ld_prio_o    = l_prio_q;
  assign irq_dis_o    = retire ? (NMB'(1) << eslot) : '0;
  assign echo_valid_o = retire && mb_rdy_i[eslot] && !mb_abort_i[eslot];
  assign echo_slot_o  = eslot;

  always_comb begin
    case (st_q)
      OP_ID:   ld_word_o = l_ext_q ? {2'b00, 1'b1, l_id_q} : {3'b000, l_id_q[10:0], 18'd0};
      OP_EN:   ld_word_o = {5'd0, 3'd3, 4'd0, 4'(l_prio_q), 16'd0};
      OP_DLO:  ld_word_o = l_data_q[31:0];
      OP_DHI:  ld_word_o = l_data_q[63:32];
      OP_GO:   ld_word_o = {8'd0, 1'b1, 2'b00, l_rtr_q, l_dlc_q, 16'd0};
      default: ld_word_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_q    <= '0;
      echo_q   <= '0;
      st_q     <= OP_IDLE;
      hold_q   <= 1'b0;
      l_idx_q  <= '0;
      l_prio_q <= '0;
      l_id_q   <= '0;
      l_ext_q  <= 1'b0;
      l_rtr_q  <= 1'b0;
      l_dlc_q  <= '0;
      l_data_q <= '0;
    end else begin
      if (accept) begin
        st_q     <= OP_DIS;
        l_idx_q  <= sel;
        l_prio_q <= nxt_q[CNT_W-1:IDX_W];
        l_id_q   <= frm_id_i;
        l_ext_q  <= frm_ext_i;
        l_rtr_q  <= frm_rtr_i;
        l_dlc_q  <= frm_dlc_i;
        l_data_q <= frm_data_i;
      end else if (go) begin
        st_q <= OP_IDLE;
      end else if (!idle) begin
        st_q <= st_q + 3'd1;
      end
      if (go) nxt_q <= nxt_q + 1'b1;
      if (go && wrap) hold_q <= 1'b1;
      else if (nxt_q == echo_q) hold_q <= 1'b0;
      if (retire) echo_q <= echo_q + 1'b1;
    end
  end

  AST_OP_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_o && ld_op_o != OP_GO) |=> (ld_valid_o && ld_op_o == $past(ld_op_o) + 3'd1)); // R2
  AST_LOAD_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_o && ld_op_o != OP_GO) |=> ($stable(ld_mb_o) && $stable(ld_prio_o))); // R2
  AST_ACCEPT_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && frm_ready_o) |-> !q_stop_o); // R3
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_busy_o |-> (!frm_ready_o && !ld_valid_o)); // R4
  AST_HOLD_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_o && ld_op_o == OP_GO && ld_mb_o == LAST_MB && ld_prio_o == '1) |=> (q_stop_o && !frm_ready_o)); // R5
  AST_RETIRE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_dis_o)); // R6
  AST_OUTSTANDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= (CNT_W+1)'(NMB)); // R6
  AST_ECHO_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    echo_valid_o |-> irq_dis_o[echo_slot_o]); // R7
endmodule

// File: tb/can_tx_mbox_sched_tb.sv
module can_tx_mbox_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic [3:0]  mb_rdy = 4'hF, mb_done = 4'h0, mb_abort = 4'h0;
  logic        frm_ready, frm_busy, ld_valid, q_stop, echo_valid;
  logic [2:0]  ld_op;
  logic [3:0]  ld_mb, ld_prio, irq_dis;
  logic [31:0] ld_word;
  logic [1:0]  echo_slot;

  can_tx_mbox_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .frm_valid_i(frm_valid), .frm_ready_o(frm_ready), .frm_busy_o(frm_busy),
    .frm_id_i(frm_id), .frm_ext_i(frm_ext), .frm_rtr_i(frm_rtr),
    .frm_dlc_i(frm_dlc), .frm_data_i(frm_data),
    .mb_rdy_i(mb_rdy), .mb_done_i(mb_done), .mb_abort_i(mb_abort),
    .ld_valid_o(ld_valid), .ld_op_o(ld_op), .ld_mb_o(ld_mb), .ld_prio_o(ld_prio),
    .ld_word_o(ld_word), .q_stop_o(q_stop),
    .echo_valid_o(echo_valid), .echo_slot_o(echo_slot), .irq_dis_o(irq_dis)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: frame counts as integers
  int m_st = 0, m_sub = 0, m_echo = 0, m_idx = 0, m_prio = 0;
  bit m_hold = 0;
  logic [28:0] m_id; logic m_ext, m_rtr; logic [3:0] m_dlc; logic [63:0] m_data;
  bit dis_pend = 0; int dis_idx = 0;

  function automatic logic [31:0] exp_word(input int st);
    case (st)
      2: return m_ext ? {2'b00, 1'b1, m_id} : {3'b000, m_id[10:0], 18'd0};
      3: return 32'(3) << 24 | 32'(m_prio) << 16;
      4: return m_data[31:0];
      5: return m_data[63:32];
      6: return 32'h0080_0000 | (32'(m_rtr) << 20) | (32'(m_dlc) << 16);
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    dis_pend = ld_valid && ld_op == 3'd1;
    dis_idx  = int'(ld_mb) - 12;
    if (!rst_n) begin
      m_st = 0; m_sub = 0; m_echo = 0; m_hold = 0;
    end else begin
      int sel, es, outst;
      bit e_ready, e_busy, e_stop, retire, e_echo;
      bit clr;
      sel     = m_sub % 4;
      es      = m_echo % 4;
      outst   = m_sub - m_echo;
      e_ready = (m_st == 0) && !m_hold && mb_rdy[sel];
      e_busy  = frm_valid && (m_st == 0) && !m_hold && !mb_rdy[sel];
      e_stop  = m_hold || !mb_rdy[sel];
      retire  = outst > 0 && mb_done[es];
      e_echo  = retire && mb_rdy[es] && !mb_abort[es];
      chk(frm_ready == e_ready, "R3", "ready", frm_ready, e_ready);
      chk(frm_busy == e_busy, "R4", "busy", frm_busy, e_busy);
      chk(q_stop == e_stop, "R9", "q_stop", q_stop, e_stop);
      chk(ld_valid == (m_st != 0), "R2", "ld_valid", ld_valid, m_st != 0);
      if (m_st != 0) begin
        chk(ld_op == 3'(m_st), "R2", "ld_op", ld_op, m_st);
        chk(ld_word == exp_word(m_st), "R2", "ld_word", ld_word, exp_word(m_st));
        chk(ld_mb == 4'(12 + m_idx), "R1", "ld_mb", ld_mb, 12 + m_idx);
        chk(ld_prio == 4'(m_prio), "R1", "ld_prio", ld_prio, m_prio);
      end
      chk(irq_dis == (retire ? 4'(1 << es) : 4'd0), "R6", "irq_dis", irq_dis,
          retire ? (1 << es) : 0);
      chk(echo_valid == e_echo, "R7", "echo_valid", echo_valid, e_echo);
      if (e_echo) chk(echo_slot == 2'(es), "R6", "echo_slot", echo_slot, es);
      // advance to the state after the coming edge
      clr = (m_sub == m_echo);
      if (m_st == 0 && e_ready && frm_valid) begin
        m_st = 1; m_idx = sel; m_prio = (m_sub / 4) % 16;
        m_id = frm_id; m_ext = frm_ext; m_rtr = frm_rtr; m_dlc = frm_dlc; m_data = frm_data;
      end else if (m_st == 6) begin
        m_st = 0;
        if (m_sub % 64 == 63) m_hold = 1; else if (clr) m_hold = 0;
        m_sub++;
      end else begin
        if (m_st != 0) m_st++;
        if (clr) m_hold = 0;
      end
      if (m_st == 0 && clr && !(m_sub % 64 == 0 && m_hold && m_sub != m_echo)) m_hold = m_hold && !clr;
      if (retire) m_echo++;
    end
  end

  // mailbox environment: a disable step marks the mailbox busy after the edge
  always @(posedge clk) begin
    #1;
    if (dis_pend && dis_idx >= 0 && dis_idx < 4) begin
      mb_rdy[dis_idx] = 1'b0; mb_done[dis_idx] = 1'b0; mb_abort[dis_idx] = 1'b0;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(input logic [28:0] id, input logic ext, input logic rtr,
                      input logic [3:0] dlc, input logic [63:0] data);
    frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc; frm_data = data;
    frm_valid = 1'b1;
    do @(negedge clk); while (!frm_ready);
    @(posedge clk); #2;
    frm_valid = 1'b0;
  endtask

  task automatic finish_mb(input int slot, input bit abort);
    mb_rdy[slot] = 1'b1; mb_done[slot] = 1'b1; mb_abort[slot] = abort;
  endtask

  int sent = 0;

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_ready == 1'b1, "R8", "reset ready", frm_ready, 1);
    chk(q_stop == 1'b0, "R8", "reset q_stop", q_stop, 0);
    chk(ld_valid == 1'b0 && echo_valid == 1'b0 && irq_dis == 4'd0, "R8", "reset idle",
        {ld_valid, echo_valid, irq_dis}, 0);
    step(1);
    // R1 R2: standard, extended and remote frames
    send(29'h123, 1'b0, 1'b0, 4'd8, 64'h1122_3344_5566_7788); sent++; step(7);
    send(29'h1ABC_DEF0, 1'b1, 1'b0, 4'd3, 64'hDEAD_BEEF_0BAD_F00D); sent++; step(7);
    send(29'h7FF, 1'b0, 1'b1, 4'd0, 64'h0); sent++; step(7);
    // R6: out-of-order completion, echoes stay in order
    finish_mb(2, 0); step(3);
    chk(echo_valid == 1'b0, "R6", "no echo before oldest done", echo_valid, 0);
    finish_mb(0, 0); finish_mb(1, 0); step(5);
    // R7: abort retires silently
    send(29'h55, 1'b0, 1'b0, 4'd2, 64'hAB); sent++; step(7);
    send(29'h66, 1'b0, 1'b0, 4'd1, 64'hCD); sent++; step(7);
    finish_mb(3, 1); finish_mb(0, 0); step(4);
    // R4: all four in flight, next offer refused
    for (int i = 0; i < 4; i++) begin
      send(29'(i + 16), 1'b0, 1'b0, 4'd4, 64'(i)); sent++; step(7);
    end
    frm_valid = 1'b1;
    @(negedge clk);
    chk(frm_busy == 1'b1 && frm_ready == 1'b0, "R4", "busy refuse", {frm_busy, frm_ready}, 2'b10);
    step(3);
    frm_valid = 1'b0;
    finish_mb(3, 0); finish_mb(2, 0); finish_mb(1, 0); finish_mb(0, 0);
    step(6);
    // R5: run to the wrap, completions overlapping loads
    while (sent % 64 != 0) begin
      int d;
      send(29'(sent * 7), sent[0], 1'b0, 4'(sent % 9), {32'(sent), 32'(~sent)});
      sent++;
      d = sent % 7;
      step(d);
      if (sent - 2 >= 9 && sent % 64 != 0) finish_mb((sent - 2) % 4, 0);
      else if (sent % 64 == 0) finish_mb((sent - 2) % 4, 0);
      step(8 - d);
    end
    frm_valid = 1'b1;
    step(3);
    @(negedge clk);
    chk(frm_ready == 1'b0 && q_stop == 1'b1, "R5", "held after wrap", {frm_ready, q_stop}, 2'b01);
    chk(frm_busy == 1'b0, "R5", "no busy while held", frm_busy, 0);
    frm_valid = 1'b0;
    step(1);
    finish_mb(3, 0);
    step(3);
    @(negedge clk);
    chk(frm_ready == 1'b1 && q_stop == 1'b0, "R5", "resume after drain", {frm_ready, q_stop}, 2'b10);
    step(1);
    send(29'h3A, 1'b0, 1'b0, 4'd5, 64'h77); sent++;
    @(negedge clk);
    chk(ld_mb == 4'd12 && ld_prio == 4'd0, "R1", "restart at mailbox 12 priority 0",
        {ld_mb, ld_prio}, 8'hC0);
    step(7);
    finish_mb(0, 0);
    step(4);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule